// File: doc/BRIEF.md
# Bridge Bus Error Status Logger

This block sits beside a bridge that joins a PCI-style expansion bus to an on-chip system bus. It receives single-cycle pulses for three kinds of error. The first is a data parity error on a read that the bridge masters. The second is an address parity error while the bridge is a target. The third is a system-bus error seen by the bridge master. For each pulse it sets sticky status bits and asks the surrounding logic for the right reaction: a system-bus error, a system-error (SERR) assertion, or a target abort.

A lockable error log keeps the address of the first failing transfer, along with a small syndrome that gives the error type and direction. It keeps that record until software unlocks it. When the bridge runs at a bus clock ratio above 2:1, it still detects errors, but it stops raising system-bus errors and stops logging. Software uses a single register port to set the enables, clear status bits by writing ones, and read the state back.

Top module: `bbe_logger`

## Requirements
- R1: After reset, all registers read zero and all three request outputs are low. Register map at reg_addr_i: 0 is status (bit0 parity-detected, bit1 SERR-signalled, bit2 master-error); 1 is control (bit0 parity-response enable, bit1 SERR enable, bit2 master-error enable, bit3 system-bus detect enable, bits5:4 response mode); 2 is syndrome (bit0 lock, bits3:1 type, bit4 direction); 3 is the logged address.
- R2: The parity-detected bit sets on any data or address parity pulse, whatever the enables are. Writing 1 to that bit clears it.
- R3: A data parity pulse with the ratio at or below 2:1 sets the master-error bit, whatever its enable is. Writing 1 clears the bit. sbus_err_req_o pulses high in the cycle after the pulse only when the master-error enable is 1.
- R4: A data parity pulse is logged only when the ratio is at or below 2:1, parity response is enabled, and the log is unlocked. Logging captures xfer_addr_i and sets the lock. While the lock is set, the address and syndrome hold.
- R5: The syndrome type is 3'b001 for a data parity error and 3'b010 for a system-bus error. The direction bit is 1 for a read and 0 for a write. For a data parity error the direction is taken from xfer_rd_i.
- R6: When ratio_gt2_i is high, a data parity pulse sets only the parity-detected bit. It sets no master-error bit, raises no request and writes nothing to the log.
- R7: When parity response is disabled, an address parity pulse does nothing beyond setting parity-detected. When parity response is enabled and the SERR enable is 1, it pulses serr_req_o in the next cycle and sets the SERR-signalled bit. With the SERR enable at 0 it does neither.
- R8: A system-bus error counts as a read (direction 1) when xfer_busy_i and xfer_rd_i are both high. In any other case, including idle, it counts as a write (direction 0).
- R9: When the system-bus detect enable is 0, a system-bus error pulse has no effect on outputs, status or log.
- R10: For a detected system-bus error, the response mode sets the reaction in the next cycle. Mode bit1 pulses tabort_req_o. Mode bit0 pulses serr_req_o and sets SERR-signalled. Mode 2'b11 does both. A detected system-bus error is logged whenever the log is unlocked.
- R11: If a status bit is set by an event in the same cycle that a write-1 clears it, the bit stays set. Writing 1 to syndrome bit0 unlocks the log.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dpar_err_i | input | 1 | Data parity error pulse on a master read |
| apar_err_i | input | 1 | Address parity error pulse while the bridge is target |
| sbus_err_i | input | 1 | System-bus error pulse seen by the bridge master |
| xfer_addr_i | input | AW | Address of the current transfer |
| xfer_rd_i | input | 1 | Current transfer is a read |
| xfer_busy_i | input | 1 | Bridge master has a transfer in progress |
| ratio_gt2_i | input | 1 | Bus clock ratio is above 2:1 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select for read and write |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Read data of the selected register |
| sbus_err_req_o | output | 1 | Request to signal a system-bus error |
| serr_req_o | output | 1 | Request to assert SERR |
| tabort_req_o | output | 1 | Request for a target abort |

## Verification
Two things can land on one status bit in the same cycle: an event that sets it and a software write-1 that clears it. The bench provokes this by driving a data parity pulse in the same cycle as a status write of all ones. It then expects parity-detected and master-error to read back as set, and it expects the system-bus request pulse to appear as usual. A second overlap is a logging event arriving while the lock is held. The bench judges this case by reading back an address that has not changed after a later error.

// File: rtl/bbe_pkg.sv
package bbe_pkg;
  localparam int unsigned NST = 3;

  localparam logic [1:0] RA_STAT = 2'd0;
  localparam logic [1:0] RA_CTRL = 2'd1;
  localparam logic [1:0] RA_SYN  = 2'd2;
  localparam logic [1:0] RA_ADDR = 2'd3;

  localparam int unsigned ST_PAR  = 0;
  localparam int unsigned ST_SERR = 1;
  localparam int unsigned ST_MST  = 2;

  typedef enum logic [2:0] {
    ET_NONE = 3'b000,
    ET_PAR  = 3'b001,
    ET_SBUS = 3'b010
  } etype_e;

  typedef struct packed {
    logic [1:0] resp_mode;
    logic       sbus_det_en;
    logic       mst_err_en;
    logic       serr_en;
    logic       par_resp_en;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);
endpackage

// File: rtl/bbe_cfg.sv
module bbe_cfg
  import bbe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= '0;
    else if (wr_i) cfg_o <= cfg_t'(wdata_i);
  end
endmodule

// File: rtl/bbe_status.sv
module bbe_status #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] stat_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic clr;
    assign clr = wr_i & wdata_i[i];
    // set beats clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stat_o[i] <= 1'b0;
      else if (set_i[i]) stat_o[i] <= 1'b1;
      else if (clr)      stat_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/bbe_evt.sv
module bbe_evt
  import bbe_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  cfg_t           cfg_i,
  input  logic           dpar_err_i,
  input  logic           apar_err_i,
  input  logic           sbus_err_i,
  input  logic           xfer_rd_i,
  input  logic           xfer_busy_i,
  input  logic           ratio_gt2_i,
  output logic [NST-1:0] set_o,
  output logic           log_req_o,
  output etype_e         log_type_o,
  output logic           log_rw_o,
  output logic           sbus_err_req_o,
  output logic           serr_req_o,
  output logic           tabort_req_o
);
  logic dpar_ok, dpar_log, sbus_hit, apar_serr, sbus_serr, sbus_tab;

  always_comb begin
    dpar_ok   = dpar_err_i & ~ratio_gt2_i;
    dpar_log  = dpar_ok & cfg_i.par_resp_en;
    sbus_hit  = sbus_err_i & cfg_i.sbus_det_en;
    apar_serr = apar_err_i & cfg_i.par_resp_en & cfg_i.serr_en;
    sbus_serr = sbus_hit & cfg_i.resp_mode[0];
    sbus_tab  = sbus_hit & cfg_i.resp_mode[1];

    set_o          = '0;
    set_o[ST_PAR]  = dpar_err_i | apar_err_i;
    set_o[ST_SERR] = apar_serr | sbus_serr;
    set_o[ST_MST]  = dpar_ok;

    // data parity has log priority over a coincident bus error
    log_req_o  = dpar_log | sbus_hit;
    log_type_o = dpar_log ? ET_PAR : ET_SBUS;
    log_rw_o   = dpar_log ? xfer_rd_i : (xfer_busy_i & xfer_rd_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sbus_err_req_o <= 1'b0;
      serr_req_o     <= 1'b0;
      tabort_req_o   <= 1'b0;
    end else begin
      sbus_err_req_o <= dpar_ok & cfg_i.mst_err_en;
      serr_req_o     <= apar_serr | sbus_serr;
      tabort_req_o   <= sbus_tab;
    end
  end
endmodule

// File: rtl/bbe_log.sv
module bbe_log
  import bbe_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  etype_e        type_i,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  input  logic          unlock_i,
  output logic          lock_o,
  output etype_e        type_o,
  output logic          rw_o,
  output logic [AW-1:0] addr_o
);
  logic cap;
  assign cap = req_i & ~lock_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_o <= 1'b0;
      type_o <= ET_NONE;
      rw_o   <= 1'b0;
      addr_o <= '0;
    end else if (cap) begin
      lock_o <= 1'b1;
      type_o <= type_i;
      rw_o   <= rw_i;
      addr_o <= addr_i;
    end else if (unlock_i) begin
      lock_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bbe_logger.sv
module bbe_logger
  import bbe_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dpar_err_i,
  input  logic          apar_err_i,
  input  logic          sbus_err_i,
  input  logic [AW-1:0] xfer_addr_i,
  input  logic          xfer_rd_i,
  input  logic          xfer_busy_i,
  input  logic          ratio_gt2_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          sbus_err_req_o,
  output logic          serr_req_o,
  output logic          tabort_req_o
);
  localparam int unsigned SYN_W = 5;

  cfg_t           cfg_q;
  logic [NST-1:0] stat_q;
  logic [NST-1:0] stat_set;
  logic           log_req, log_rw, log_rw_q, log_lock_q;
  etype_e         log_type, log_type_q;
  logic [AW-1:0]  log_addr_q;
  logic           wr_stat, wr_ctrl, wr_syn;
  logic [SYN_W-1:0] syn;

  assign wr_stat = reg_we_i & (reg_addr_i == RA_STAT);
  assign wr_ctrl = reg_we_i & (reg_addr_i == RA_CTRL);
  assign wr_syn  = reg_we_i & (reg_addr_i == RA_SYN) & reg_wdata_i[0];

  bbe_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_ctrl),
    .wdata_i (reg_wdata_i[CFG_W-1:0]),
    .cfg_o   (cfg_q)
  );

  bbe_evt u_evt (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cfg_i          (cfg_q),
    .dpar_err_i     (dpar_err_i),
    .apar_err_i     (apar_err_i),
    .sbus_err_i     (sbus_err_i),
    .xfer_rd_i      (xfer_rd_i),
    .xfer_busy_i    (xfer_busy_i),
    .ratio_gt2_i    (ratio_gt2_i),
    .set_o          (stat_set),
    .log_req_o      (log_req),
    .log_type_o     (log_type),
    .log_rw_o       (log_rw),
    .sbus_err_req_o (sbus_err_req_o),
    .serr_req_o     (serr_req_o),
    .tabort_req_o   (tabort_req_o)
  );

  bbe_status #(.N(NST)) u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (stat_set),
    .wr_i    (wr_stat),
    .wdata_i (reg_wdata_i[NST-1:0]),
    .stat_o  (stat_q)
  );

  bbe_log #(.AW(AW)) u_log (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (log_req),
    .type_i   (log_type),
    .rw_i     (log_rw),
    .addr_i   (xfer_addr_i),
    .unlock_i (wr_syn),
    .lock_o   (log_lock_q),
    .type_o   (log_type_q),
    .rw_o     (log_rw_q),
    .addr_o   (log_addr_q)
  );

  assign syn = {log_rw_q, log_type_q, log_lock_q};

  always_comb begin
    unique case (reg_addr_i)
      RA_STAT: reg_rdata_o = DW'(stat_q);
      RA_CTRL: reg_rdata_o = DW'(cfg_q);
      RA_SYN:  reg_rdata_o = DW'(syn);
      default: reg_rdata_o = DW'(log_addr_q);
    endcase
  end
endmodule

// File: rtl/bbe_logger_chk.sv
module bbe_logger_chk
  import bbe_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           dpar_err_i,
  input logic           apar_err_i,
  input logic           sbus_err_i,
  input logic           ratio_gt2_i,
  input logic           reg_we_i,
  input logic [1:0]     reg_addr_i,
  input logic [DW-1:0]  reg_wdata_i,
  input logic           sbus_err_req_o,
  input logic           serr_req_o,
  input logic           tabort_req_o,
  input cfg_t           cfg_q,
  input logic [NST-1:0] stat_q,
  input logic           log_lock_q,
  input logic [AW-1:0]  log_addr_q
);
  logic unlock_wr;
  assign unlock_wr = reg_we_i && reg_addr_i == RA_SYN && reg_wdata_i[0];

  AST_PAR_DET_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dpar_err_i || apar_err_i) |=> stat_q[ST_PAR]); // R2

  AST_SBUS_REQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sbus_err_req_o |-> $past(dpar_err_i && !ratio_gt2_i && cfg_q.mst_err_en)); // R3

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (log_lock_q && !unlock_wr) |=> ($stable(log_addr_q) && log_lock_q)); // R4

  AST_RATIO_NO_LOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_gt2_i && dpar_err_i && !sbus_err_i) |=> $stable(log_addr_q)); // R6

  AST_SERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_req_o |-> $past((apar_err_i && cfg_q.par_resp_en && cfg_q.serr_en) ||
                         (sbus_err_i && cfg_q.sbus_det_en && cfg_q.resp_mode[0]))); // R7

  AST_NO_DET_NO_TABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tabort_req_o |-> $past(sbus_err_i && cfg_q.sbus_det_en)); // R9

  AST_TABORT_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tabort_req_o |-> $past(cfg_q.resp_mode[1])); // R10
endmodule

bind bbe_logger bbe_logger_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .dpar_err_i     (dpar_err_i),
  .apar_err_i     (apar_err_i),
  .sbus_err_i     (sbus_err_i),
  .ratio_gt2_i    (ratio_gt2_i),
  .reg_we_i       (reg_we_i),
  .reg_addr_i     (reg_addr_i),
  .reg_wdata_i    (reg_wdata_i),
  .sbus_err_req_o (sbus_err_req_o),
  .serr_req_o     (serr_req_o),
  .tabort_req_o   (tabort_req_o),
  .cfg_q          (cfg_q),
  .stat_q         (stat_q),
  .log_lock_q     (log_lock_q),
  .log_addr_q     (log_addr_q)
);

// File: tb/sim_bbe_logger.sv
module sim_bbe_logger;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SEL_OUT = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          dpar_err_i = 1'b0, apar_err_i = 1'b0, sbus_err_i = 1'b0;
  logic [AW-1:0] xfer_addr_i = '0;
  logic          xfer_rd_i = 1'b0, xfer_busy_i = 1'b0, ratio_gt2_i = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [1:0]    reg_addr_i = '0;
  logic [DW-1:0] reg_wdata_i = '0;
  logic [DW-1:0] reg_rdata_o;
  logic          sbus_err_req_o, serr_req_o, tabort_req_o;

  always #2 clk_i = ~clk_i;

  bbe_logger #(.AW(AW), .DW(DW)) u0 (.*);

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // monitor: one expected item per cycle, sampled mid-cycle
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.sel == SEL_OUT) ? {29'b0, tabort_req_o, serr_req_o, sbus_err_req_o}
                                : reg_rdata_o;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask

  task automatic expect_v(int sel, logic [31:0] exp, string req);
    item_t it;
    if (sel < SEL_OUT) reg_addr_i = 2'(sel);
    it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
    cyc();
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    cyc();
    reg_we_i = 1'b0;
  endtask

  // kind: 0 data parity, 1 address parity, 2 system-bus error
  task automatic pulse(int kind, logic [31:0] a, logic rd, logic busy);
    xfer_addr_i = a; xfer_rd_i = rd; xfer_busy_i = busy;
    dpar_err_i = (kind == 0); apar_err_i = (kind == 1); sbus_err_i = (kind == 2);
    cyc();
    dpar_err_i = 1'b0; apar_err_i = 1'b0; sbus_err_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    expect_v(0, 0, "R1"); expect_v(1, 0, "R1"); expect_v(2, 0, "R1");
    expect_v(3, 0, "R1"); expect_v(SEL_OUT, 0, "R1");

    wr(2'd1, 32'h3F);
    expect_v(1, 32'h3F, "R1");

    // R3 R4 R5 first data parity error is logged
    pulse(0, 32'h1000_0040, 1'b1, 1'b1);
    expect_v(SEL_OUT, 1, "R3");
    expect_v(0, 5, "R2");
    expect_v(2, 32'h13, "R5");
    expect_v(3, 32'h1000_0040, "R4");

    // R4 lock holds
    pulse(0, 32'h2000_0080, 1'b0, 1'b1);
    expect_v(SEL_OUT, 1, "R3");
    expect_v(3, 32'h1000_0040, "R4");
    expect_v(2, 32'h13, "R4");

    // R2 R11 clear and unlock
    wr(2'd0, 32'h5);
    expect_v(0, 0, "R2");
    wr(2'd2, 32'h1);
    expect_v(2, 32'h12, "R11");

    // R6 ratio above 2:1
    ratio_gt2_i = 1'b1;
    pulse(0, 32'h3000_0000, 1'b1, 1'b1);
    ratio_gt2_i = 1'b0;
    expect_v(SEL_OUT, 0, "R6");
    expect_v(0, 1, "R6");
    expect_v(3, 32'h1000_0040, "R6");
    expect_v(2, 32'h12, "R6");
    wr(2'd0, 32'h1);

    // R4 parity response off: status and request yes, log no
    wr(2'd1, 32'h3E);
    pulse(0, 32'h4000_0000, 1'b1, 1'b1);
    expect_v(SEL_OUT, 1, "R3");
    expect_v(0, 5, "R3");
    expect_v(3, 32'h1000_0040, "R4");
    wr(2'd0, 32'h5);

    // R7 address parity masked
    pulse(1, 32'h0, 1'b0, 1'b0);
    expect_v(SEL_OUT, 0, "R7");
    expect_v(0, 1, "R2");
    wr(2'd0, 32'h1);
    wr(2'd1, 32'h3F);
    pulse(1, 32'h0, 1'b0, 1'b0);
    expect_v(SEL_OUT, 2, "R7");
    expect_v(0, 3, "R7");
    wr(2'd0, 32'h3);
    wr(2'd1, 32'h3D);
    pulse(1, 32'h0, 1'b0, 1'b0);
    expect_v(SEL_OUT, 0, "R7");
    expect_v(0, 1, "R7");
    wr(2'd0, 32'h1);

    // R10 R8 system-bus errors
    wr(2'd1, 32'h2F);
    pulse(2, 32'h5000_0010, 1'b1, 1'b1);
    expect_v(SEL_OUT, 4, "R10");
    expect_v(0, 0, "R10");
    expect_v(2, 32'h15, "R8");
    expect_v(3, 32'h5000_0010, "R10");
    wr(2'd2, 32'h1);
    wr(2'd1, 32'h1F);
    pulse(2, 32'h6000_0020, 1'b1, 1'b0);
    expect_v(SEL_OUT, 2, "R10");
    expect_v(0, 2, "R10");
    expect_v(2, 32'h5, "R8");
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h2);
    wr(2'd1, 32'h3F);
    pulse(2, 32'h7000_0030, 1'b0, 1'b1);
    expect_v(SEL_OUT, 6, "R10");
    expect_v(2, 32'h5, "R8");
    expect_v(3, 32'h7000_0030, "R10");
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h2);

    // R9 detection disabled
    wr(2'd1, 32'h37);
    pulse(2, 32'h8000_0000, 1'b1, 1'b1);
    expect_v(SEL_OUT, 0, "R9");
    expect_v(0, 0, "R9");
    expect_v(3, 32'h7000_0030, "R9");
    expect_v(2, 32'h4, "R9");

    // R11 set wins over same-cycle clear
    wr(2'd1, 32'h3F);
    reg_we_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 32'h7;
    pulse(0, 32'h9000_0000, 1'b1, 1'b1);
    reg_we_i = 1'b0;
    expect_v(SEL_OUT, 1, "R11");
    expect_v(0, 5, "R11");
    expect_v(3, 32'h9000_0000, "R11");

    // R3 master-error enable off
    wr(2'd0, 32'h7);
    wr(2'd2, 32'h1);
    wr(2'd1, 32'h3B);
    pulse(0, 32'hA000_0000, 1'b0, 1'b1);
    expect_v(SEL_OUT, 0, "R3");
    expect_v(0, 5, "R3");
    expect_v(2, 32'h3, "R5");
    expect_v(3, 32'hA000_0000, "R4");

    cyc();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule